// File: doc/BRIEF.md
# USB Device Address Register with Staged Commit

This block holds the 7-bit address that a device-side USB controller answers to. Software writes it through a plain register port at a fixed byte offset. A write can take effect at once, or it can be staged. A staged value is parked in a shadow register and moves into the live address only when the controller reports that an IN transaction on control endpoint 0 has finished. This matches the protocol rule that the device keeps its old address until the status stage of an address assignment has completed.

The live address drives the packet matcher continuously. The event input is a single-cycle pulse that carries the number of the endpoint whose IN transaction completed. Only endpoint 0 can release a staged address. The register read returns the staged value, with its flag set, while a commit is outstanding; otherwise it returns the live address.

Top module: `usb_dev_addr_reg`

## Requirements
- R1: After reset, `dev_addr` is 0, no commit is pending, and a read at the register offset returns 0.
- R2: A write to offset 0x144 with bit 24 clear loads bits 31:25 into `dev_addr` on the next clock edge and discards any pending staged value.
- R3: A write to offset 0x144 with bit 24 set leaves `dev_addr` unchanged. The address in bits 31:25 is held pending until a cycle with `in_done` high and `in_ep` equal to 0, after which `dev_addr` takes the pending value on the next clock edge.
- R4: An `in_done` pulse with `in_ep` not equal to 0 changes neither `dev_addr` nor the pending state.
- R5: A read at offset 0x144 returns {pending address in bits 31:25, 1 in bit 24} while a commit is pending, and {`dev_addr` in bits 31:25, 0 in bit 24} otherwise. Bits 23:0 always read as 0.
- R6: A second staged write before the commit replaces the pending address, and only the last staged value is committed.
- R7: Writes to any other offset are ignored, and reads at any other offset return 0.
- R8: When a staged write and an endpoint-0 commit fall in the same cycle, `dev_addr` takes the older pending value and the new value stays pending. When an immediate write and a commit fall in the same cycle, the written value wins and nothing stays pending.
- R9: An endpoint-0 `in_done` with nothing pending leaves `dev_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_ofs | input | 12 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_ofs` |
| in_done | input | 1 | Single-cycle pulse: an IN transaction completed |
| in_ep | input | 4 | Endpoint number that goes with `in_done` |
| dev_addr | output | 7 | Active device address for the packet matcher |

## Verification
A register write and an endpoint-0 completion can land in the same cycle. The outcome then depends on whether the write is staged or immediate. The bench drives both collisions directly: a staged write together with a commit, while a value is already pending, and an immediate write together with a commit. It then checks `dev_addr` and the read-back flag in the following cycle against the ordering given in R8. Random traffic biased toward the register offset and endpoint 0 hits further collisions, and a bench reference model judges every one of them cycle by cycle.

// File: rtl/usbda_pkg.sv
package usbda_pkg;
   typedef enum logic [1:0] {
      WK_NONE  = 2'd0,
      WK_IMM   = 2'd1,
      WK_STAGE = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/usbda_decode.sv
module usbda_decode
   import usbda_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          OFS_W      = 12,
   parameter logic [11:0] REG_OFS    = 12'h144,
   parameter int          ADDR_W     = 7,
   parameter int          ADDR_LSB   = 25,
   parameter int          STAGE_BIT  = 24,
   parameter bit          STAGING_EN = 1'b1,
   parameter int          EP_W       = 4
) (
   input  logic              reg_wr,
   input  logic [OFS_W-1:0]  reg_ofs,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              in_done,
   input  logic [EP_W-1:0]   in_ep,
   output wr_kind_e          kind,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              commit
);
   logic hit;
   logic stage_req;
   logic unused_wdata;

   assign unused_wdata = ^reg_wdata;
   assign hit     = reg_wr && (reg_ofs == REG_OFS[OFS_W-1:0]);
   assign wr_addr = reg_wdata[ADDR_LSB +: ADDR_W];
   assign commit  = in_done && (in_ep == '0);

   generate
      if (STAGING_EN) begin : g_stage
         assign stage_req = reg_wdata[STAGE_BIT];
      end else begin : g_nostage
         assign stage_req = 1'b0;
      end
   endgenerate

   always_comb begin
      kind = WK_NONE;
      if (hit) kind = stage_req ? WK_STAGE : WK_IMM;
   end
endmodule

// File: rtl/usbda_shadow.sv
module usbda_shadow
   import usbda_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_kind_e          kind,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              commit,
   output logic              pend,
   output logic [ADDR_W-1:0] pend_addr,
   output logic              take
);
   assign take = commit && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_addr <= '0;
      end else begin
         if (kind == WK_STAGE) begin
            pend      <= 1'b1;
            pend_addr <= wr_addr;
         end else if (kind == WK_IMM || take) begin
            pend <= 1'b0;
         end
      end
   end

   // R6
   restage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kind == WK_STAGE |=> pend && pend_addr == $past(wr_addr));
endmodule

// File: rtl/usbda_active.sv
module usbda_active
   import usbda_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_kind_e          kind,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              take,
   input  logic [ADDR_W-1:0] pend_addr,
   output logic [ADDR_W-1:0] act
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              act <= '0;
      else if (kind == WK_IMM) act <= wr_addr;
      else if (take)           act <= pend_addr;
   end
endmodule

// File: rtl/usbda_readback.sv
module usbda_readback #(
   parameter int          DATA_W    = 32,
   parameter int          OFS_W     = 12,
   parameter logic [11:0] REG_OFS   = 12'h144,
   parameter int          ADDR_W    = 7,
   parameter int          ADDR_LSB  = 25,
   parameter int          STAGE_BIT = 24
) (
   input  logic [OFS_W-1:0]  reg_ofs,
   input  logic              pend,
   input  logic [ADDR_W-1:0] pend_addr,
   input  logic [ADDR_W-1:0] act,
   output logic [DATA_W-1:0] reg_rdata
);
   always_comb begin
      reg_rdata = '0;
      if (reg_ofs == REG_OFS[OFS_W-1:0]) begin
         reg_rdata[ADDR_LSB +: ADDR_W] = pend ? pend_addr : act;
         reg_rdata[STAGE_BIT]          = pend;
      end
   end
endmodule

// File: rtl/usb_dev_addr_reg.sv
module usb_dev_addr_reg
   import usbda_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          OFS_W      = 12,
   parameter logic [11:0] REG_OFS    = 12'h144,
   parameter int          ADDR_W     = 7,
   parameter int          ADDR_LSB   = 25,
   parameter int          STAGE_BIT  = 24,
   parameter bit          STAGING_EN = 1'b1,
   parameter int          EP_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [OFS_W-1:0]  reg_ofs,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              in_done,
   input  logic [EP_W-1:0]   in_ep,
   output logic [ADDR_W-1:0] dev_addr
);
   generate
      if (ADDR_LSB + ADDR_W > DATA_W) begin : g_bad_field
         $error("address field exceeds data width");
      end
      if (STAGE_BIT >= ADDR_LSB || STAGE_BIT < 0) begin : g_bad_stage
         $error("staging flag must sit below the address field");
      end
      if (OFS_W > 12 || OFS_W < 1) begin : g_bad_ofs
         $error("offset width out of range");
      end
   endgenerate

   wr_kind_e          kind;
   logic [ADDR_W-1:0] wr_addr;
   logic              commit;
   logic              pend;
   logic [ADDR_W-1:0] pend_addr;
   logic              take;

   usbda_decode #(
      .DATA_W(DATA_W), .OFS_W(OFS_W), .REG_OFS(REG_OFS), .ADDR_W(ADDR_W),
      .ADDR_LSB(ADDR_LSB), .STAGE_BIT(STAGE_BIT), .STAGING_EN(STAGING_EN),
      .EP_W(EP_W)
   ) u_decode (
      .reg_wr(reg_wr), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
      .in_done(in_done), .in_ep(in_ep),
      .kind(kind), .wr_addr(wr_addr), .commit(commit)
   );

   usbda_shadow #(.ADDR_W(ADDR_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .kind(kind), .wr_addr(wr_addr),
      .commit(commit), .pend(pend), .pend_addr(pend_addr), .take(take)
   );

   usbda_active #(.ADDR_W(ADDR_W)) u_active (
      .clk(clk), .rst_n(rst_n), .kind(kind), .wr_addr(wr_addr),
      .take(take), .pend_addr(pend_addr), .act(dev_addr)
   );

   usbda_readback #(
      .DATA_W(DATA_W), .OFS_W(OFS_W), .REG_OFS(REG_OFS), .ADDR_W(ADDR_W),
      .ADDR_LSB(ADDR_LSB), .STAGE_BIT(STAGE_BIT)
   ) u_readback (
      .reg_ofs(reg_ofs), .pend(pend), .pend_addr(pend_addr),
      .act(dev_addr), .reg_rdata(reg_rdata)
   );

   // R2
   imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_ofs == REG_OFS[OFS_W-1:0] &&
       (!STAGING_EN || !reg_wdata[STAGE_BIT]))
      |=> dev_addr == $past(reg_wdata[ADDR_LSB +: ADDR_W]) && !pend);

   // R3
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != WK_IMM && !(in_done && in_ep == '0)) |=> $stable(dev_addr));

   // R4
   foreign_ep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WK_NONE && in_done && in_ep != '0)
      |=> $stable(dev_addr) && $stable(pend) && $stable(pend_addr));

   // R8
   commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_done && in_ep == '0 && pend && kind != WK_IMM)
      |=> dev_addr == $past(pend_addr));

   // R9
   idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_done && !pend && kind == WK_NONE) |=> $stable(dev_addr));
endmodule

// File: tb/tb_usb_dev_addr_reg.sv
`timescale 1ns/1ps
module tb_usb_dev_addr_reg;
   localparam logic [11:0] OFS = 12'h144;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [11:0] reg_ofs;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        in_done;
   logic [3:0]  in_ep;
   logic [6:0]  dev_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [6:0] m_act;
   logic       m_pend;
   logic [6:0] m_pval;

   always #2 clk = ~clk;

   usb_dev_addr_reg dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_done(in_done),
      .in_ep(in_ep), .dev_addr(dev_addr)
   );

   function automatic logic [31:0] exp_read(logic [11:0] o);
      if (o != OFS) return 32'h0;
      return m_pend ? {m_pval, 1'b1, 24'h0} : {m_act, 1'b0, 24'h0};
   endfunction

   function automatic logic [31:0] mk(logic [6:0] a, logic stg, logic [23:0] junk);
      return {a, stg, junk};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(logic wr, logic [11:0] o, logic [31:0] wd, logic dn, logic [3:0] ep);
      @(negedge clk);
      reg_wr = wr; reg_ofs = o; reg_wdata = wd; in_done = dn; in_ep = ep;
      @(posedge clk);
      if (wr && o == OFS && !wd[24]) begin
         m_act = wd[31:25]; m_pend = 1'b0;
      end else begin
         if (dn && ep == 4'd0 && m_pend) begin
            m_act = m_pval; m_pend = 1'b0;
         end
         if (wr && o == OFS) begin
            m_pend = 1'b1; m_pval = wd[31:25];
         end
      end
      #1;
      @(negedge clk);
      reg_wr = 1'b0; in_done = 1'b0;
      #0.5;
   endtask

   task automatic chk_both(string req);
      check(req, {25'h0, dev_addr}, {25'h0, m_act});
      check(req, reg_rdata, exp_read(reg_ofs));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0144));
      m_act = '0; m_pend = 1'b0; m_pval = '0;
      rst_n = 1'b0; reg_wr = 1'b0; reg_ofs = OFS; reg_wdata = '0;
      in_done = 1'b0; in_ep = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #0.5;
      // R1 reset state
      check("R1", {25'h0, dev_addr}, 32'h0);
      check("R1", reg_rdata, 32'h0);

      // R2 immediate write
      cyc(1, OFS, mk(7'h12, 0, 24'hABCDEF), 0, 0);
      chk_both("R2");
      check("R5", reg_rdata, 32'h2400_0000);

      // R3 staged write holds
      cyc(1, OFS, mk(7'h34, 1, 24'h123456), 0, 0);
      check("R3", {25'h0, dev_addr}, 32'h12);
      check("R5", reg_rdata, {7'h34, 1'b1, 24'h0});

      // R4 foreign endpoint
      cyc(0, OFS, 0, 1, 4'd3);
      check("R4", {25'h0, dev_addr}, 32'h12);
      check("R4", reg_rdata, {7'h34, 1'b1, 24'h0});

      // R6 restage then commit
      cyc(1, OFS, mk(7'h55, 1, 0), 0, 0);
      check("R6", reg_rdata, {7'h55, 1'b1, 24'h0});
      cyc(0, OFS, 0, 1, 4'd0);
      check("R6", {25'h0, dev_addr}, 32'h55);
      check("R3", reg_rdata, {7'h55, 1'b0, 24'h0});

      // R9 commit with nothing pending
      cyc(0, OFS, 0, 1, 4'd0);
      check("R9", {25'h0, dev_addr}, 32'h55);

      // R7 other offset
      cyc(1, 12'h148, mk(7'h7F, 0, 0), 0, 0);
      check("R7", {25'h0, dev_addr}, 32'h55);
      check("R7", reg_rdata, 32'h0);
      cyc(1, 12'h148, mk(7'h7E, 1, 0), 0, 0);
      cyc(0, OFS, 0, 0, 0);
      check("R7", reg_rdata, {7'h55, 1'b0, 24'h0});

      // R8 staged write colliding with commit
      cyc(1, OFS, mk(7'h01, 1, 0), 0, 0);
      cyc(1, OFS, mk(7'h02, 1, 0), 1, 4'd0);
      check("R8", {25'h0, dev_addr}, 32'h01);
      check("R8", reg_rdata, {7'h02, 1'b1, 24'h0});
      // R8 immediate write colliding with commit
      cyc(1, OFS, mk(7'h03, 0, 0), 1, 4'd0);
      check("R8", {25'h0, dev_addr}, 32'h03);
      check("R8", reg_rdata, {7'h03, 1'b0, 24'h0});

      // R2 immediate write discards pending
      cyc(1, OFS, mk(7'h44, 1, 0), 0, 0);
      cyc(1, OFS, mk(7'h45, 0, 0), 0, 0);
      cyc(0, OFS, 0, 1, 4'd0);
      check("R2", {25'h0, dev_addr}, 32'h45);

      // random traffic, R3/R5 against the model
      for (int i = 0; i < 600; i++) begin
         logic        w  = ($urandom % 3) == 0;
         logic [11:0] o  = ($urandom % 4) != 0 ? OFS : 12'($urandom);
         logic [31:0] wd = $urandom;
         logic        dn = ($urandom % 3) == 0;
         logic [3:0]  ep = ($urandom % 2) != 0 ? 4'd0 : 4'($urandom);
         cyc(w, o, wd, dn, ep);
         chk_both("R3");
         check("R5", reg_rdata & 32'h00FF_FFFF, 32'h0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule